// File: doc/BRIEF.md
# Multi-Lane Client Receive Interface

This block is the receive side of one client attached to a buffer-less on-chip network. The router in front of it keeps no storage, so every link that the router drives towards the client ends in a private FIFO lane inside this block. A link can only be stalled by its own lane filling up, and no link ever waits on another.

All lanes share a single read bus towards the client. That bus carries `PACK` flits per word, so it can drain a lane faster than a link fills it. Lanes take turns on the bus in round-robin order. A lane that wins the bus keeps it until the word holding its packet's tail flit has been taken, so the client always sees one packet at a time as a run of words from one lane. Lane count, FIFO depth, flit width and packing factor are parameters, chosen to suit the traffic expected by the application.

Top module: `rxl_client_rx`

## Requirements
- R1: Every link has its own lane. A flit is taken on a clock edge where `lnk_valid[i]` and `lnk_ready[i]` are both high. The flits of one lane reach the bus in arrival order with their data unchanged, and none is lost or duplicated.
- R2: `lnk_ready[i]` is low exactly while lane i holds `DEPTH` flits. A flit offered while it is low is not taken and stays offered. The other lanes' ready signals are unaffected.
- R3: A bus word carries 1 to `PACK` flits, all from one lane. The oldest flit sits in bits [FLIT_W-1:0], the next in the following FLIT_W bits, and so on. `bus_count` gives the number of flits in the word, and the slices above that count are zero.
- R4: A word never extends past a tail flit. `bus_last` is high on, and only on, the word that carries the tail. A word with fewer than `PACK` flits is always a last word.
- R5: `bus_first` is high on the word whose lowest slice is a head flit, which is the first word of every packet.
- R6: A lane competes for the bus only once it holds a complete packet or at least `PACK` flits. A single non-tail flit alone in a lane never raises `bus_valid`.
- R7: Lanes are granted round-robin, searching upward from the lane after the one granted most recently, with wrap-around. After reset, lane 0 is first in the search.
- R8: Once a lane is granted, every word on the bus comes from that lane until its word with `bus_last` has been transferred.
- R9: While `bus_valid` is high and `bus_ready` is low, the word and all its sideband fields stay unchanged on the next cycle.
- R10: During and directly after reset, `bus_valid` is low and every `lnk_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lnk_valid | input | NUM_LANES | Per-link flit valid |
| lnk_data | input | NUM_LANES*FLIT_W | Per-link flit payload; lane i occupies bits [i*FLIT_W +: FLIT_W] |
| lnk_head | input | NUM_LANES | Flit is the first of its packet |
| lnk_tail | input | NUM_LANES | Flit is the last of its packet |
| lnk_ready | output | NUM_LANES | Lane has room for a flit |
| bus_valid | output | 1 | A word is offered to the client |
| bus_ready | input | 1 | Client takes the word on this edge |
| bus_lane | output | max(1,clog2(NUM_LANES)) | Binary index of the lane the word comes from |
| bus_data | output | PACK*FLIT_W | Packed flits, oldest in the lowest slice |
| bus_count | output | clog2(PACK+1) | Number of flits in the word |
| bus_first | output | 1 | Word begins a packet |
| bus_last | output | 1 | Word ends a packet |

## Verification
The properties assume that every link delivers well-formed packets: a head on the first flit, a tail on the last, and the flits of one packet in sequence on one link. The stimulus keeps to this by building every packet from a single loop that sets head on the first iteration and tail on the last. It interleaves packets only across lanes. Each link holds a flit and its marks steady until the flit is accepted, which matches the handshake the lanes expect. The client side is free to drop `bus_ready` at any time, so the stimulus toggles it pseudo-randomly to exercise the hold-under-stall property.

// File: rtl/rxl_pkg.sv
package rxl_pkg;

    // Width of an index into n items, never less than one bit.
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Width of a counter able to hold the value n.
    function automatic int cnt_w(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/rxl_lane_fifo.sv
// One lane: circular store of flits with head/tail marks.
// DEPTH must be a power of two, at least 2, and at least PACK.
module rxl_lane_fifo #(
    parameter int FLIT_W = 8,
    parameter int DEPTH  = 8,
    parameter int PACK   = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic [FLIT_W-1:0]            in_data,
    input  logic                         in_head,
    input  logic                         in_tail,
    output logic                         in_ready,
    input  logic [rxl_pkg::cnt_w(PACK)-1:0] pop_cnt,
    output logic [PACK*FLIT_W-1:0]       peek_data,
    output logic [PACK-1:0]              peek_tail,
    output logic [PACK-1:0]              peek_vld,
    output logic                         peek_head,
    output logic                         word_rdy
);
    localparam int AW   = rxl_pkg::idx_w(DEPTH);
    localparam int CNTW = rxl_pkg::cnt_w(DEPTH);
    localparam int CW   = rxl_pkg::cnt_w(PACK);
    localparam int EW   = FLIT_W + 2;
    localparam int TB   = FLIT_W;
    localparam int HB   = FLIT_W + 1;

    typedef struct packed {
        logic [AW-1:0]   wr;
        logic [AW-1:0]   rd;
        logic [CNTW-1:0] cnt;
        logic [CNTW-1:0] tails;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [EW-1:0] mem [DEPTH];
    logic push;
    logic popped_tail;

    assign in_ready = (st_q.cnt != CNTW'(DEPTH));
    assign push     = in_valid && in_ready;
    assign word_rdy = (st_q.cnt >= CNTW'(PACK)) || (st_q.tails != '0);

    always_comb begin
        st_d        = st_q;
        popped_tail = 1'b0;
        for (int i = 0; i < PACK; i++) begin
            if (CW'(i) < pop_cnt) begin
                popped_tail = popped_tail | mem[st_q.rd + AW'(i)][TB];
            end
        end
        st_d.wr    = st_q.wr + AW'(push);
        st_d.rd    = st_q.rd + AW'(pop_cnt);
        st_d.cnt   = st_q.cnt + CNTW'(push) - CNTW'(pop_cnt);
        st_d.tails = st_q.tails + CNTW'(push && in_tail) - CNTW'(popped_tail);
    end

    always_comb begin
        for (int i = 0; i < PACK; i++) begin
            peek_data[i*FLIT_W +: FLIT_W] = mem[st_q.rd + AW'(i)][FLIT_W-1:0];
            peek_tail[i]                  = mem[st_q.rd + AW'(i)][TB];
            peek_vld[i]                   = CNTW'(i) < st_q.cnt;
        end
        peek_head = mem[st_q.rd][HB];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            mem[st_q.wr] <= {in_head, in_tail, in_data};
        end
    end

endmodule

// File: rtl/rxl_rr_arb.sv
// Round-robin grant that stays locked on one lane until the packet ends.
module rxl_rr_arb #(
    parameter int N = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N-1:0]                elig,
    input  logic                        done,
    output logic                        grant_vld,
    output logic [rxl_pkg::idx_w(N)-1:0] grant_idx
);
    localparam int LW = rxl_pkg::idx_w(N);

    typedef struct packed {
        logic          locked;
        logic [LW-1:0] owner;
        logic [LW-1:0] last;
    } arb_st_t;

    arb_st_t st_d, st_q;
    logic          found;
    logic [LW-1:0] pick;

    always_comb begin
        st_d  = st_q;
        found = 1'b0;
        pick  = st_q.last;
        for (int i = 1; i <= N; i++) begin
            int cand;
            cand = (int'(st_q.last) + i) % N;
            if (!found && elig[cand]) begin
                found = 1'b1;
                pick  = LW'(cand);
            end
        end
        if (!st_q.locked) begin
            if (found) begin
                st_d.locked = 1'b1;
                st_d.owner  = pick;
            end
        end else if (done) begin
            st_d.locked = 1'b0;
            st_d.last   = st_q.owner;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.locked <= 1'b0;
            st_q.owner  <= '0;
            st_q.last   <= LW'(N - 1);
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_vld = st_q.locked;
    assign grant_idx = st_q.owner;

endmodule

// File: rtl/rxl_packer.sv
// Builds one bus word from the oldest flits of the granted lane,
// stopping after a tail flit.
module rxl_packer #(
    parameter int FLIT_W = 8,
    parameter int PACK   = 2
) (
    input  logic [PACK*FLIT_W-1:0]          peek_data,
    input  logic [PACK-1:0]                 peek_tail,
    input  logic [PACK-1:0]                 peek_vld,
    input  logic                            peek_head,
    output logic [PACK*FLIT_W-1:0]          w_data,
    output logic [rxl_pkg::cnt_w(PACK)-1:0] w_count,
    output logic                            w_first,
    output logic                            w_last
);
    localparam int CW = rxl_pkg::cnt_w(PACK);

    always_comb begin
        logic stop;
        stop    = 1'b0;
        w_data  = '0;
        w_count = '0;
        w_last  = 1'b0;
        for (int i = 0; i < PACK; i++) begin
            if (peek_vld[i] && !stop) begin
                w_data[i*FLIT_W +: FLIT_W] = peek_data[i*FLIT_W +: FLIT_W];
                w_count                    = CW'(i + 1);
                if (peek_tail[i]) begin
                    w_last = 1'b1;
                    stop   = 1'b1;
                end
            end
        end
        w_first = peek_vld[0] && peek_head;
    end

endmodule

// File: rtl/rxl_client_rx.sv
module rxl_client_rx #(
    parameter int NUM_LANES = 4,
    parameter int FLIT_W    = 8,
    parameter int DEPTH     = 8,
    parameter int PACK      = 2
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [NUM_LANES-1:0]                 lnk_valid,
    input  logic [NUM_LANES*FLIT_W-1:0]          lnk_data,
    input  logic [NUM_LANES-1:0]                 lnk_head,
    input  logic [NUM_LANES-1:0]                 lnk_tail,
    output logic [NUM_LANES-1:0]                 lnk_ready,
    output logic                                 bus_valid,
    input  logic                                 bus_ready,
    output logic [rxl_pkg::idx_w(NUM_LANES)-1:0] bus_lane,
    output logic [PACK*FLIT_W-1:0]               bus_data,
    output logic [rxl_pkg::cnt_w(PACK)-1:0]      bus_count,
    output logic                                 bus_first,
    output logic                                 bus_last
);
    localparam int LW = rxl_pkg::idx_w(NUM_LANES);
    localparam int CW = rxl_pkg::cnt_w(PACK);
    localparam int WW = PACK * FLIT_W;

    logic [WW-1:0]        pk_data [NUM_LANES];
    logic [PACK-1:0]      pk_tail [NUM_LANES];
    logic [PACK-1:0]      pk_vld  [NUM_LANES];
    logic [NUM_LANES-1:0] pk_head;
    logic [NUM_LANES-1:0] lane_rdy;
    logic [CW-1:0]        pop     [NUM_LANES];

    logic          grant_vld;
    logic [LW-1:0] grant_idx;
    logic          xfer;

    assign bus_valid = grant_vld && lane_rdy[grant_idx];
    assign xfer      = bus_valid && bus_ready;
    assign bus_lane  = grant_idx;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        assign pop[g] = (xfer && grant_idx == LW'(g)) ? bus_count : '0;

        rxl_lane_fifo #(
            .FLIT_W (FLIT_W),
            .DEPTH  (DEPTH),
            .PACK   (PACK)
        ) u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (lnk_valid[g]),
            .in_data   (lnk_data[g*FLIT_W +: FLIT_W]),
            .in_head   (lnk_head[g]),
            .in_tail   (lnk_tail[g]),
            .in_ready  (lnk_ready[g]),
            .pop_cnt   (pop[g]),
            .peek_data (pk_data[g]),
            .peek_tail (pk_tail[g]),
            .peek_vld  (pk_vld[g]),
            .peek_head (pk_head[g]),
            .word_rdy  (lane_rdy[g])
        );
    end

    rxl_rr_arb #(
        .N (NUM_LANES)
    ) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .elig      (lane_rdy),
        .done      (xfer && bus_last),
        .grant_vld (grant_vld),
        .grant_idx (grant_idx)
    );

    rxl_packer #(
        .FLIT_W (FLIT_W),
        .PACK   (PACK)
    ) u_pack (
        .peek_data (pk_data[grant_idx]),
        .peek_tail (pk_tail[grant_idx]),
        .peek_vld  (pk_vld[grant_idx]),
        .peek_head (pk_head[grant_idx]),
        .w_data    (bus_data),
        .w_count   (bus_count),
        .w_first   (bus_first),
        .w_last    (bus_last)
    );

endmodule

// File: rtl/rxl_client_rx_chk.sv
module rxl_client_rx_chk #(
    parameter int NUM_LANES = 4,
    parameter int FLIT_W    = 8,
    parameter int PACK      = 2
) (
    input logic                                 clk,
    input logic                                 rst_n,
    input logic                                 bus_valid,
    input logic                                 bus_ready,
    input logic [rxl_pkg::idx_w(NUM_LANES)-1:0] bus_lane,
    input logic [PACK*FLIT_W-1:0]               bus_data,
    input logic [rxl_pkg::cnt_w(PACK)-1:0]      bus_count,
    input logic                                 bus_first,
    input logic                                 bus_last
);
    localparam int CW = rxl_pkg::cnt_w(PACK);

    p_count_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (bus_count != '0 && bus_count <= CW'(PACK)));

    p_partial_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_count != CW'(PACK)) |-> bus_last);

    p_first_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_ready && bus_last) |=> (!bus_valid || bus_first));

    p_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_ready && !bus_last) |=> (!bus_valid || bus_lane == $past(bus_lane)));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_data) && $stable(bus_lane)
            && $stable(bus_count) && $stable(bus_first) && $stable(bus_last)));

endmodule

bind rxl_client_rx rxl_client_rx_chk #(
    .NUM_LANES (NUM_LANES),
    .FLIT_W    (FLIT_W),
    .PACK      (PACK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_ready (bus_ready),
    .bus_lane  (bus_lane),
    .bus_data  (bus_data),
    .bus_count (bus_count),
    .bus_first (bus_first),
    .bus_last  (bus_last)
);

// File: tb/rxl_client_rx_tb.sv
module rxl_client_rx_tb;
    localparam int N  = 4;
    localparam int FW = 8;
    localparam int DP = 8;
    localparam int PK = 2;
    localparam int EM = 512;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [N-1:0]   lv, lh, lt;
    logic [FW-1:0]  ld [N];
    logic [N*FW-1:0] lnk_data;
    logic [N-1:0]   lnk_ready;
    logic           bus_valid, bus_rdy, bus_first, bus_last;
    logic [1:0]     bus_lane;
    logic [PK*FW-1:0] bus_data;
    logic [1:0]     bus_count;

    int checks = 0;
    int fails  = 0;

    logic [FW+1:0] exp_mem [N][EM];
    int  wr_i [N];
    int  rd_i [N];
    logic [5:0] seq [N];
    int  log_lane [256];
    int  log_n = 0;
    bit  in_pkt = 0;
    int  cur_lane = 0;
    bit  hold_pend = 0;
    logic [PK*FW+5:0] hold_val;
    bit  done_rand = 0;

    always #5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) lnk_data[i*FW +: FW] = ld[i];
    end

    rxl_client_rx #(.NUM_LANES(N), .FLIT_W(FW), .DEPTH(DP), .PACK(PK)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .lnk_valid(lv), .lnk_data(lnk_data), .lnk_head(lh), .lnk_tail(lt),
        .lnk_ready(lnk_ready),
        .bus_valid(bus_valid), .bus_ready(bus_rdy), .bus_lane(bus_lane),
        .bus_data(bus_data), .bus_count(bus_count),
        .bus_first(bus_first), .bus_last(bus_last)
    );

    task automatic chk(input bit ok, input string req, input string msg);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s", req, msg);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Offer one flit on a lane and hold it until accepted (R1, R2).
    task automatic send_flit(input int ln, input bit h, input bit t);
        lv[ln] = 1'b1;
        lh[ln] = h;
        lt[ln] = t;
        ld[ln] = {ln[1:0], seq[ln]};
        forever begin
            @(negedge clk);
            if (lnk_ready[ln]) break;
            tick();
        end
        exp_mem[ln][wr_i[ln]] = {h, t, ld[ln]};
        wr_i[ln]++;
        seq[ln]++;
        tick();
        lv[ln] = 1'b0;
    endtask

    task automatic send_packet(input int ln, input int len, input bit gaps);
        for (int f = 0; f < len; f++) begin
            send_flit(ln, f == 0, f == len - 1);
            if (gaps) repeat ($urandom % 3) tick();
        end
    endtask

    task automatic push_multi(input logic [N-1:0] m);
        fork
            begin if (m[0]) send_flit(0, 1'b1, 1'b1); end
            begin if (m[1]) send_flit(1, 1'b1, 1'b1); end
            begin if (m[2]) send_flit(2, 1'b1, 1'b1); end
            begin if (m[3]) send_flit(3, 1'b1, 1'b1); end
        join
    endtask

    // Bus monitor: expected word computed from the per-lane flit record.
    always @(negedge clk) begin
        if (rst_n) begin
            if (hold_pend) begin
                chk(bus_valid && {bus_data, bus_lane, bus_count, bus_first, bus_last} == hold_val,
                    "R9", $sformatf("held word act=%h exp=%h valid=%0d",
                    {bus_data, bus_lane, bus_count, bus_first, bus_last}, hold_val, bus_valid));
            end
            hold_pend = bus_valid && !bus_rdy;
            hold_val  = {bus_data, bus_lane, bus_count, bus_first, bus_last};
            if (bus_valid && bus_rdy) begin
                int ln;
                int ecnt;
                bit elast, efirst;
                logic [PK*FW-1:0] edata;
                ln = int'(bus_lane);
                ecnt = 0; elast = 0; efirst = 0; edata = '0;
                for (int i = 0; i < PK; i++) begin
                    if (!elast && rd_i[ln] + i < wr_i[ln]) begin
                        logic [FW+1:0] e;
                        e = exp_mem[ln][rd_i[ln] + i];
                        if (i == 0) efirst = e[FW+1];
                        edata[i*FW +: FW] = e[FW-1:0];
                        ecnt++;
                        elast = e[FW];
                    end
                end
                chk(bus_data == edata, "R1", $sformatf("lane %0d data act=%h exp=%h", ln, bus_data, edata));
                chk(int'(bus_count) == ecnt, "R3", $sformatf("lane %0d count act=%0d exp=%0d", ln, bus_count, ecnt));
                chk(bus_last == elast, "R4", $sformatf("lane %0d last act=%0d exp=%0d", ln, bus_last, elast));
                chk(bus_first == efirst, "R5", $sformatf("lane %0d first act=%0d exp=%0d", ln, bus_first, efirst));
                if (in_pkt) begin
                    chk(ln == cur_lane, "R8", $sformatf("lane switch mid packet act=%0d exp=%0d", ln, cur_lane));
                end
                rd_i[ln] += ecnt;
                in_pkt   = !bus_last;
                cur_lane = ln;
                if (bus_last && log_n < 256) begin
                    log_lane[log_n] = ln;
                    log_n++;
                end
            end
        end
    end

    initial begin
        #2000000;
        checks++;
        fails++;
        $display("FAIL watchdog: act=timeout exp=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int n0;
        rst_n = 1'b0;
        lv = '0; lh = '0; lt = '0;
        bus_rdy = 1'b0;
        for (int i = 0; i < N; i++) begin
            ld[i] = '0; wr_i[i] = 0; rd_i[i] = 0; seq[i] = '0;
        end
        repeat (3) tick();
        @(negedge clk);
        chk(!bus_valid && lnk_ready == '1, "R10",
            $sformatf("in reset valid=%0d ready=%b exp valid=0 ready=1111", bus_valid, lnk_ready));
        tick();
        rst_n = 1'b1;
        @(negedge clk);
        chk(!bus_valid && lnk_ready == '1, "R10",
            $sformatf("after reset valid=%0d ready=%b exp valid=0 ready=1111", bus_valid, lnk_ready));
        tick();

        // R7: simultaneous single-flit packets on all lanes
        n0 = log_n;
        push_multi(4'b1111);
        bus_rdy = 1'b1;
        repeat (20) tick();
        for (int i = 0; i < 4; i++)
            chk(log_n >= n0 + 4 && log_lane[n0 + i] == i, "R7",
                $sformatf("grant %0d act=%0d exp=%0d", i, log_lane[n0 + i], i));
        bus_rdy = 1'b0;
        n0 = log_n;
        push_multi(4'b0101);
        bus_rdy = 1'b1;
        repeat (12) tick();
        chk(log_n == n0 + 2 && log_lane[n0] == 0 && log_lane[n0 + 1] == 2, "R7",
            $sformatf("order act=%0d,%0d exp=0,2", log_lane[n0], log_lane[n0 + 1]));
        bus_rdy = 1'b0;
        n0 = log_n;
        push_multi(4'b1010);
        bus_rdy = 1'b1;
        repeat (12) tick();
        chk(log_n == n0 + 2 && log_lane[n0] == 3 && log_lane[n0 + 1] == 1, "R7",
            $sformatf("order act=%0d,%0d exp=3,1", log_lane[n0], log_lane[n0 + 1]));

        // R6: a lone non-tail flit is not eligible
        send_flit(1, 1'b1, 1'b0);
        repeat (4) begin
            @(negedge clk);
            chk(!bus_valid, "R6", $sformatf("lone flit valid act=%0d exp=0", bus_valid));
        end
        tick();
        send_flit(1, 1'b0, 1'b0);
        @(negedge clk);
        @(negedge clk);
        chk(bus_valid && bus_lane == 2'd1 && bus_count == 2'd2, "R6",
            $sformatf("two flits valid=%0d lane=%0d count=%0d exp 1,1,2", bus_valid, bus_lane, bus_count));
        tick();
        send_flit(1, 1'b0, 1'b1);
        repeat (8) tick();

        // R2: fill lane 2 to DEPTH with the bus stalled
        bus_rdy = 1'b0;
        for (int f = 0; f < DP; f++) begin
            send_flit(2, f == 0, 1'b0);
            if (f == DP - 2) begin
                @(negedge clk);
                chk(lnk_ready[2], "R2", $sformatf("ready at %0d flits act=%0d exp=1", DP - 1, lnk_ready[2]));
                tick();
            end
        end
        @(negedge clk);
        chk(lnk_ready == 4'b1011, "R2", $sformatf("ready when lane 2 full act=%b exp=1011", lnk_ready));
        tick();
        fork
            send_flit(2, 1'b0, 1'b0);
            begin
                repeat (3) begin
                    @(negedge clk);
                    chk(!lnk_ready[2] && lv[2], "R2",
                        $sformatf("full lane took flit ready=%0d exp=0", lnk_ready[2]));
                end
                tick();
                bus_rdy = 1'b1;
            end
        join
        send_flit(2, 1'b0, 1'b1);
        repeat (20) tick();

        // Random traffic on all lanes with a stalling client
        fork
            begin
                fork
                    for (int p = 0; p < 40; p++) send_packet(0, 1 + $urandom % 6, 1'b1);
                    for (int p = 0; p < 40; p++) send_packet(1, 1 + $urandom % 6, 1'b1);
                    for (int p = 0; p < 40; p++) send_packet(2, 1 + $urandom % 6, 1'b1);
                    for (int p = 0; p < 40; p++) send_packet(3, 1 + $urandom % 6, 1'b1);
                join
                done_rand = 1;
            end
            begin
                while (!done_rand) begin
                    tick();
                    bus_rdy = ($urandom % 4) != 0;
                end
            end
        join
        bus_rdy = 1'b1;
        repeat (60) tick();
        @(negedge clk);
        for (int i = 0; i < N; i++)
            chk(rd_i[i] == wr_i[i], "R1",
                $sformatf("lane %0d delivered act=%0d exp=%0d", i, rd_i[i], wr_i[i]));
        chk(!bus_valid && lnk_ready == '1, "R1",
            $sformatf("idle end valid=%0d ready=%b exp 0,1111", bus_valid, lnk_ready));

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule